// File: doc/BRIEF.md
# Host-to-Microcontroller Mailbox Register Block

This block connects a processor's register bus to a small peripheral microcontroller. The host reaches it through a simple strobe interface with three 32-bit registers. It writes command bytes into a transmit queue and reads reply bytes out of a receive queue. On the microcontroller side, each queue appears as a byte stream with a valid/ready handshake. Both queues are eight entries deep by default.

The block watches four queue conditions:

- transmit queue empty
- transmit queue has room
- receive queue holds data
- a receive byte was lost to a full queue

Each condition latches a request bit when it starts. Each request bit has its own enable. One interrupt line is high while any enabled request is pending. Software clears request bits, and the sticky loss flag, by writing ones to the status register. It can therefore acknowledge everything it saw by writing back the status value it just read.

Top module: `mbx_regs`

## Requirements
- R1: Register word addresses are 0 for the interrupt register, 1 for the data register and 2 for the status register. Reads of any other address return zero, and writes to them change nothing.
- R2: A host write to address 1 queues bits 15:8 of the write data for transmission. The microcontroller side presents the oldest queued byte on `tx_byte` with `tx_valid`, and that byte leaves the queue on a cycle where `tx_ready` is also high.
- R3: The transmit queue holds DEPTH (8) bytes. A host write while it is full is dropped.
- R4: A host read of address 1 returns the oldest received byte in bits 15:8, with all other bits zero, and removes that byte. A read while the queue is empty returns zero and removes nothing.
- R5: The receive queue holds DEPTH bytes and `rx_ready` is high from the first clock after reset. A byte offered while the queue is full is dropped and sets status bit 3, which stays set until cleared.
- R6: Status bits 0, 1 and 2 show, at all times, transmit empty, transmit not full and receive not empty. Bits above 3 read zero.
- R7: Interrupt register bits 0 to 3 are requests in the same order as status bits 0 to 3. Bits 0 to 2 are set the clock after their status bit goes from 0 to 1. Bit 3 is set by each dropped receive byte. A set request stays set until it is cleared.
- R8: Writing the status register clears each request bit whose position holds a one. A one in bit 3 also clears the sticky loss flag. A new setting event in the same cycle wins over the clear.
- R9: Interrupt register bits 4 to 7 are enables for requests 0 to 3. A write to the interrupt register loads them. Bits 3:0 of that write have no effect.
- R10: `irq` is high exactly when some request bit and its enable are both one.
- R11: After reset, the interrupt register reads 0, the status register reads 0x3, and `irq` and `tx_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of the strobe |
| tx_byte | output | 8 | Oldest transmit byte |
| tx_valid | output | 1 | Transmit queue not empty |
| tx_ready | input | 1 | Microcontroller takes the byte |
| rx_byte | input | 8 | Byte from the microcontroller |
| rx_valid | input | 1 | rx_byte is offered |
| rx_ready | output | 1 | Receive side accepts (high after reset) |
| irq | output | 1 | Combined enabled request line |

## Verification
Directed sequences check the exact boundaries:

- A ninth transmit write into a full transmit queue.
- A ninth incoming byte into a full receive queue.
- A read from the empty receive queue.
- Writes to the interrupt register's request bits.
- Writing back a status value just read.

Together these separate a correct drop from an off-by-one depth, and a real write-one-to-clear from a plain register write. A long seeded random mix then interleaves host writes and reads, incoming bytes, microcontroller takes, partial clears and enable changes. Its reference model tracks the queues and the edges of each condition. This shows whether requests latch only on a start and not on a level, whether they survive unrelated clears, and whether irq follows the enables.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   // register word addresses
   localparam int unsigned REG_INTR = 0;
   localparam int unsigned REG_DATA = 1;
   localparam int unsigned REG_STAT = 2;

   // number of monitored conditions; the bit order is shared by status,
   // request and enable fields
   localparam int unsigned NCOND = 4;

   typedef struct packed {
      logic rx_lost;     // bit 3
      logic rx_has;      // bit 2
      logic tx_room;     // bit 1
      logic tx_idle;     // bit 0
   } cond_t;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full,
   output logic         drop
);
   localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = $clog2(DEPTH + 1);
   localparam bit          POW2 = (DEPTH & (DEPTH - 1)) == 0;

   if (DEPTH < 2) begin : g_chk_depth
      $error("mbx_fifo: DEPTH must be at least 2");
   end
   if (W < 1) begin : g_chk_width
      $error("mbx_fifo: W must be at least 1");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] rd_ptr, wr_ptr, rd_nxt, wr_nxt;
   logic [CW-1:0] count;
   logic          do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign drop    = push && full;
   assign dout    = mem[rd_ptr];

   if (POW2) begin : g_wrap_free
      assign rd_nxt = rd_ptr + 1'b1;
      assign wr_nxt = wr_ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R3/R5: a push into a full queue must not change its occupancy
   p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> full);
   // R4: popping an empty queue leaves it empty
   p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push) |=> empty);
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq #(
   parameter int unsigned          N       = 4,
   parameter logic [N-1:0]         LVL_RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,      // level conditions, latched on rise
   input  logic [N-1:0] evt,      // pulse conditions, latched directly
   input  logic [N-1:0] clr,      // write-one-to-clear strobes
   input  logic         en_we,
   input  logic [N-1:0] en_in,
   output logic [N-1:0] req,
   output logic [N-1:0] en,
   output logic         irq
);
   if (N < 1) begin : g_chk_n
      $error("mbx_irq: N must be at least 1");
   end

   logic [N-1:0] lvl_q;
   logic [N-1:0] set;

   assign set = (lvl & ~lvl_q) | evt;
   assign irq = |(req & en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= LVL_RST;
         req   <= '0;
         en    <= '0;
      end else begin
         lvl_q <= lvl;
         req   <= (req & ~clr) | set;
         if (en_we) en <= en_in;
      end
   end

   // R7: a pending request survives any cycle without a clear of its bit
   p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req != '0) |=> (($past(req) & ~$past(clr) & ~req) == '0));
   // R10: with all enables off the line stays low
   p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (en == '0) |-> !irq);
endmodule

// File: rtl/mbx_regs.sv
module mbx_regs
   import mbx_pkg::*;
#(
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned BYTE_LSB = 8,
   parameter int unsigned DEPTH    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [7:0]        tx_byte,
   output logic              tx_valid,
   input  logic              tx_ready,
   input  logic [7:0]        rx_byte,
   input  logic              rx_valid,
   output logic              rx_ready,
   output logic              irq
);
   localparam int unsigned BYTE_MSB = BYTE_LSB + 7;
   localparam int unsigned EN_LSB   = NCOND;

   if (BYTE_MSB >= DATA_W) begin : g_chk_lane
      $error("mbx_regs: byte lane does not fit the data word");
   end
   if (DATA_W < 2 * NCOND) begin : g_chk_dw
      $error("mbx_regs: data word too narrow for request and enable fields");
   end
   if ((1 << ADDR_W) <= REG_STAT) begin : g_chk_aw
      $error("mbx_regs: ADDR_W too small to reach every register");
   end

   logic hit_intr, hit_data, hit_stat;
   logic wr_intr, wr_data, wr_stat, rd_data;

   assign hit_intr = bus_addr == ADDR_W'(REG_INTR);
   assign hit_data = bus_addr == ADDR_W'(REG_DATA);
   assign hit_stat = bus_addr == ADDR_W'(REG_STAT);
   assign wr_intr  = bus_sel &&  bus_wr && hit_intr;
   assign wr_data  = bus_sel &&  bus_wr && hit_data;
   assign wr_stat  = bus_sel &&  bus_wr && hit_stat;
   assign rd_data  = bus_sel && !bus_wr && hit_data;

   // transmit queue: host -> microcontroller
   logic tx_empty, tx_full, tx_drop;
   mbx_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (wr_data),
      .din   (bus_wdata[BYTE_MSB:BYTE_LSB]),
      .pop   (tx_ready),
      .dout  (tx_byte),
      .empty (tx_empty),
      .full  (tx_full),
      .drop  (tx_drop)
   );
   assign tx_valid = !tx_empty;

   // receive queue: microcontroller -> host
   logic       rx_empty, rx_full, rx_drop, rx_rdy_q;
   logic [7:0] rx_head;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rx_rdy_q <= 1'b0;
      else        rx_rdy_q <= 1'b1;
   end
   assign rx_ready = rx_rdy_q;

   mbx_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (rx_valid && rx_rdy_q),
      .din   (rx_byte),
      .pop   (rd_data),
      .dout  (rx_head),
      .empty (rx_empty),
      .full  (rx_full),
      .drop  (rx_drop)
   );

   // write-one-to-clear strobes from the status register
   logic [NCOND-1:0] clr;
   assign clr = wr_stat ? bus_wdata[NCOND-1:0] : '0;

   // sticky loss flag; a new loss wins over a clear in the same cycle
   logic lost_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lost_q <= 1'b0;
      else if (rx_drop) lost_q <= 1'b1;
      else if (clr[3])  lost_q <= 1'b0;
   end

   cond_t stat;
   assign stat.rx_lost = lost_q;
   assign stat.rx_has  = !rx_empty;
   assign stat.tx_room = !tx_full;
   assign stat.tx_idle = tx_empty;

   cond_t lvl, evt;
   always_comb begin
      lvl         = stat;
      lvl.rx_lost = 1'b0;
      evt         = '0;
      evt.rx_lost = rx_drop;
   end

   logic [NCOND-1:0] req, en;
   mbx_irq #(.N(NCOND), .LVL_RST(NCOND'(4'b0011))) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (lvl),
      .evt   (evt),
      .clr   (clr),
      .en_we (wr_intr),
      .en_in (bus_wdata[EN_LSB +: NCOND]),
      .req   (req),
      .en    (en),
      .irq   (irq)
   );

   // read path, combinational in the strobe cycle
   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr) begin
         if (hit_intr) begin
            bus_rdata[NCOND-1:0]       = req;
            bus_rdata[EN_LSB +: NCOND] = en;
         end else if (hit_data) begin
            if (!rx_empty) bus_rdata[BYTE_MSB:BYTE_LSB] = rx_head;
         end else if (hit_stat) begin
            bus_rdata[NCOND-1:0] = stat;
         end
      end
   end

   // R2: a byte held on the stream waits unchanged until taken
   p_tx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));
   // R5: the loss flag stays set without a clearing write
   p_lost_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (lost_q && !clr[3]) |=> lost_q);
   // R5: a dropped receive byte always shows up as a latched request
   p_lost_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_drop |=> (req[3] && lost_q));
   // R1: reserved reads return zero
   p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && !hit_intr && !hit_data && !hit_stat) |-> (bus_rdata == '0));
endmodule

// File: tb/mbx_regs_test.sv
module mbx_regs_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  tx_byte;
   logic        tx_valid;
   logic        tx_ready = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic        rx_valid = 1'b0;
   logic        rx_ready;
   logic        irq;

   always #5 clk = ~clk;

   mbx_regs uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_ready(rx_ready), .irq(irq)
   );

   int checks = 0, fails = 0;
   bit done = 1'b0;

   // reference model
   logic [7:0] txq[$];
   logic [7:0] rxq[$];
   logic [3:0] m_req = '0, m_en = '0;
   logic       m_lost = 1'b0;
   logic [2:0] m_prev = 3'b011;

   function automatic logic [31:0] exp_stat();
      return {28'd0, m_lost, rxq.size() > 0, txq.size() < 8, txq.size() == 0};
   endfunction
   function automatic logic [31:0] exp_intr();
      return {24'd0, m_en, m_req};
   endfunction
   function automatic logic exp_irq();
      return |(m_req & m_en);
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic edges();
      logic [2:0] cur;
      cur = exp_stat();
      m_req[2:0] = m_req[2:0] | (cur & ~m_prev);
      m_prev = cur;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_write(logic [3:0] a, logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic verify(string ctx);
      logic [31:0] d;
      idle(2);
      bus_read(4'd2, d);
      check({"R6 status ", ctx}, d, exp_stat());
      bus_read(4'd0, d);
      check({"R7 R9 intr ", ctx}, d, exp_intr());
      check({"R10 irq ", ctx}, {31'd0, irq}, {31'd0, exp_irq()});
   endtask

   // operations, each updating the model
   task automatic op_send(logic [7:0] b);
      bus_write(4'd1, {16'hA5C3, b, 8'h3C});
      if (txq.size() < 8) txq.push_back(b);   // R3 drop when full
      edges();
   endtask

   task automatic op_recv_read();
      logic [31:0] d, e;
      bus_read(4'd1, d);
      if (rxq.size() > 0) e = {16'd0, rxq.pop_front(), 8'd0};
      else e = 32'd0;
      check("R4 data read", d, e);
      edges();
   endtask

   task automatic op_incoming(logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1; rx_byte = b;
      @(negedge clk);
      rx_valid = 1'b0;
      if (rxq.size() < 8) rxq.push_back(b);
      else begin m_lost = 1'b1; m_req[3] = 1'b1; end   // R5
      edges();
   endtask

   task automatic op_take();
      @(negedge clk);
      check("R2 tx_valid", {31'd0, tx_valid}, {31'd0, txq.size() > 0});
      if (txq.size() > 0) check("R2 tx_byte", {24'd0, tx_byte}, {24'd0, txq[0]});
      tx_ready = 1'b1;
      @(negedge clk);
      tx_ready = 1'b0;
      if (txq.size() > 0) void'(txq.pop_front());
      edges();
   endtask

   task automatic op_clear(logic [31:0] w);
      bus_write(4'd2, w);                    // R8
      m_req = m_req & ~w[3:0];
      if (w[3]) m_lost = 1'b0;
      edges();
   endtask

   task automatic op_enable(logic [31:0] w);
      bus_write(4'd0, w);                    // R9: bits 3:0 ignored
      m_en = w[7:4];
      edges();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] d;
      void'($urandom(32'h1357_2468));
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R11 reset state
      check("R11 irq", {31'd0, irq}, 32'd0);
      check("R11 tx_valid", {31'd0, tx_valid}, 32'd0);
      check("R5 rx_ready", {31'd0, rx_ready}, 32'd1);
      bus_read(4'd0, d); check("R11 intr", d, 32'd0);
      bus_read(4'd2, d); check("R11 status", d, 32'h3);

      // R1 reserved addresses
      bus_read(4'd3, d);  check("R1 reserved 3", d, 32'd0);
      bus_read(4'd15, d); check("R1 reserved 15", d, 32'd0);
      bus_write(4'd3, 32'hFFFF_FFFF);
      bus_write(4'd7, 32'hFFFF_FFFF);
      verify("R1 after reserved writes");

      // R9 request bits in an interrupt write do nothing
      op_enable(32'h0000_004F);
      verify("R9 enable only");

      // R7 receive-not-empty request, R10 irq, R4 read and empty read
      op_incoming(8'h5A);
      verify("R7 rx rise");
      op_recv_read();
      op_recv_read();
      verify("R4 empty read");
      op_clear(32'h4);
      verify("R8 clear rx req");

      // R3 transmit full and drop, R2 order
      for (int i = 0; i < 9; i++) op_send(8'h10 + 8'(i));
      verify("R3 tx full");
      for (int i = 0; i < 9; i++) op_take();
      verify("R2 drained");

      // R5 receive overflow, sticky
      op_enable(32'h0000_0080);
      for (int i = 0; i < 9; i++) op_incoming(8'hC0 + 8'(i));
      verify("R5 overflow");
      op_clear(32'h7);
      verify("R5 sticky after partial clear");

      // R8 write back the read status value
      bus_read(4'd2, d);
      op_clear(d);
      verify("R8 write-back");
      for (int i = 0; i < 8; i++) op_recv_read();
      op_clear(32'hF);
      verify("R8 all clear");

      // constrained random mix
      for (int it = 0; it < 400; it++) begin
         int unsigned k;
         k = $urandom_range(0, 99);
         if (k < 22)      op_send(8'($urandom));
         else if (k < 42) op_recv_read();
         else if (k < 64) op_incoming(8'($urandom));
         else if (k < 84) op_take();
         else if (k < 94) op_clear($urandom & 32'hF);
         else             op_enable($urandom & 32'hFF);
         if (it % 4 == 0) verify("random");
      end
      verify("random end");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule